// File: doc/BRIEF.md
# Blinking Floor Digit Driver

This block drives a single seven-segment digit that shows the floor where an elevator car is. It turns a small floor index into seven active-high segment lines and has no digit-select outputs, because the display it feeds holds only one digit. When the car stops at a floor, the controller pulses an arrival strobe. The digit then flashes five times, once per second, and after that it stays lit.

A one-second tick from a shared timebase marks where each flash ends. Inside each flash, a local counter that runs at the clock rate (`CLK_HZ`) sets the half-second boundary. For the first half of each flash the digit is shown, and for the rest of it the digit is blanked. A new arrival during a flash sequence starts the count of five again. The outputs come from registers, so they change one clock after the inputs that cause the change.

Top module: `floor_digit_blinker`

## Requirements
- R1: The segments are active-high. `seg_out[6]` is segment a, and the bits run down to `seg_out[0]`, which is segment g. The glyphs are: 0 lights a,b,c,d,e,f. 1 lights b,c. 2 lights a,b,d,e,g. 3 lights a,b,c,d,g. 4 lights b,c,f,g.
- R2: Floor indices 0 to 4 show the digits 0 to 4. Any index above 4 blanks all seven segments, and this also applies during a flash sequence.
- R3: While `rst` is high at a clock edge, `seg_out` becomes 0 and `blink_on` becomes 0. After reset the block is idle and shows the floor steadily.
- R4: An `arrive` pulse starts a flash sequence. `blink_on` is 1 from the next output update onward.
- R5: Within each flash, the digit is shown for the first `CLK_HZ/2` clock cycles, counted from the arrival or from the last tick. After that it stays blank until the next `sec_tick`.
- R6: Each `sec_tick` during a sequence ends one flash. The fifth tick ends the sequence: `blink_on` drops and the digit stays lit.
- R7: An `arrive` during a sequence restarts the count of five. If `arrive` and `sec_tick` are high in the same cycle, the arrival wins and the tick is not counted.
- R8: `sec_tick` has no effect while idle: the digit stays lit and `blink_on` stays 0.
- R9: The outputs are registered. A change of `floor_idx` appears on `seg_out` one clock later.
- R10: If the floor index changes during a sequence, the new glyph is shown in the lit half of each flash. The flash count is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| floor_idx | input | FLOOR_W | Current floor index |
| arrive | input | 1 | One-cycle strobe: the car has stopped at a floor |
| sec_tick | input | 1 | One-cycle pulse once per second |
| seg_out | output | 7 | Segments a (bit 6) to g (bit 0), 1 = lit |
| blink_on | output | 1 | High while a flash sequence is running |

## Verification
The flash counter and the restart logic can act in the same cycle when `arrive` and `sec_tick` are both high. The bench provokes this during a running sequence and also from idle. It judges the result by counting how many further ticks it takes before `blink_on` drops: exactly five are expected, which shows the tick from the shared cycle was not counted. Tick spacing is varied: shorter than the half period, so the digit never blanks, and much longer, so the digit stays dark for several cycles. Each cycle is compared against a model computed from the rules above.

// File: rtl/floor_digit_pkg.sv
package floor_digit_pkg;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;
  // Bit positions: a is the most significant bit, g the least.
  localparam int SEG_A = 6;
  localparam int SEG_B = 5;
  localparam int SEG_C = 4;
  localparam int SEG_D = 3;
  localparam int SEG_E = 2;
  localparam int SEG_F = 1;
  localparam int SEG_G = 0;
  localparam seg_t SEG_BLANK = '0;
endpackage

// File: rtl/fd_glyph_rom.sv
module fd_glyph_rom
  import floor_digit_pkg::*;
#(
  parameter int FLOOR_W   = 3,
  parameter int MAX_FLOOR = 4
) (
  input  logic [FLOOR_W-1:0] idx,
  output seg_t               glyph
);
  always_comb begin
    glyph = SEG_BLANK;
    if (idx <= FLOOR_W'(MAX_FLOOR)) begin
      case (int'(idx))
        0: begin
          glyph[SEG_A] = 1'b1; glyph[SEG_B] = 1'b1; glyph[SEG_C] = 1'b1;
          glyph[SEG_D] = 1'b1; glyph[SEG_E] = 1'b1; glyph[SEG_F] = 1'b1;
        end
        1: begin
          glyph[SEG_B] = 1'b1; glyph[SEG_C] = 1'b1;
        end
        2: begin
          glyph[SEG_A] = 1'b1; glyph[SEG_B] = 1'b1; glyph[SEG_D] = 1'b1;
          glyph[SEG_E] = 1'b1; glyph[SEG_G] = 1'b1;
        end
        3: begin
          glyph[SEG_A] = 1'b1; glyph[SEG_B] = 1'b1; glyph[SEG_C] = 1'b1;
          glyph[SEG_D] = 1'b1; glyph[SEG_G] = 1'b1;
        end
        4: begin
          glyph[SEG_B] = 1'b1; glyph[SEG_C] = 1'b1;
          glyph[SEG_F] = 1'b1; glyph[SEG_G] = 1'b1;
        end
        default: glyph = SEG_BLANK;
      endcase
    end
  end
endmodule

// File: rtl/fd_half_timer.sv
module fd_half_timer #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic lit_phase
);
  localparam int HALF = (CLK_HZ / 2 > 0) ? CLK_HZ / 2 : 1;
  localparam int CW   = $clog2(HALF + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (cnt != CW'(HALF)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign lit_phase = (cnt < CW'(HALF));

  // The count always returns to zero after a restart.
  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));
  // The count never runs past the half-period limit.
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(HALF));
endmodule

// File: rtl/fd_blink_seq.sv
module fd_blink_seq #(
  parameter int BLINKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic arrive,
  input  logic sec_tick,
  output logic active
);
  localparam int BW = (BLINKS > 1) ? $clog2(BLINKS) : 1;

  logic [BW-1:0] done_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      done_cnt <= '0;
    end else if (arrive) begin
      active   <= 1'b1;
      done_cnt <= '0;
    end else if (active && sec_tick) begin
      if (done_cnt == BW'(BLINKS - 1)) begin
        active   <= 1'b0;
        done_cnt <= '0;
      end else begin
        done_cnt <= done_cnt + 1'b1;
      end
    end
  end

  // An arrival always opens a fresh sequence.
  assert_arrive_restarts_R7: assert property (@(posedge clk) disable iff (rst)
    arrive |=> (active && done_cnt == '0));
  // Without a tick or an arrival, the sequence holds its place.
  assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (active && !arrive && !sec_tick) |=> (active && $stable(done_cnt)));
  // While idle, a tick does not start anything.
  assert_idle_tick_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (!active && !arrive) |=> !active);
  // The flash count stays in range.
  assert_count_range_R6: assert property (@(posedge clk) disable iff (rst)
    done_cnt <= BW'(BLINKS - 1));
endmodule

// File: rtl/floor_digit_blinker.sv
module floor_digit_blinker
  import floor_digit_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BLINKS    = 5,
  parameter int FLOOR_W   = 3,
  parameter int MAX_FLOOR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FLOOR_W-1:0] floor_idx,
  input  logic               arrive,
  input  logic               sec_tick,
  output logic [6:0]         seg_out,
  output logic               blink_on
);
  seg_t glyph;
  logic lit_phase;
  logic seq_active;

  fd_glyph_rom #(.FLOOR_W(FLOOR_W), .MAX_FLOOR(MAX_FLOOR)) u_rom (
    .idx   (floor_idx),
    .glyph (glyph)
  );

  fd_half_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (arrive || sec_tick),
    .lit_phase (lit_phase)
  );

  fd_blink_seq #(.BLINKS(BLINKS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .arrive   (arrive),
    .sec_tick (sec_tick),
    .active   (seq_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_out  <= SEG_BLANK;
      blink_on <= 1'b0;
    end else begin
      seg_out  <= (seq_active && !lit_phase) ? SEG_BLANK : glyph;
      blink_on <= seq_active;
    end
  end

  // An out-of-range floor index always blanks the digit.
  assert_invalid_blank_R2: assert property (@(posedge clk) disable iff (rst)
    (floor_idx > FLOOR_W'(MAX_FLOOR)) |=> (seg_out == SEG_BLANK));
  // In the dark half of a flash the digit is off.
  assert_dark_half_R5: assert property (@(posedge clk) disable iff (rst)
    (seq_active && !lit_phase) |=> (seg_out == SEG_BLANK));
  // While idle, the digit follows the floor index one clock later.
  assert_idle_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (!seq_active) |=> (seg_out == $past(glyph) && !blink_on));
endmodule

// File: tb/sim_floor_digit_blinker.sv
module sim_floor_digit_blinker;
  localparam int CLK_PERIOD = 10;
  localparam int HZ   = 8;
  localparam int HALF = HZ / 2;
  localparam int NBL  = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] floor_idx = '0;
  logic       arrive = 1'b0;
  logic       sec_tick = 1'b0;
  logic [6:0] seg_out;
  logic       blink_on;

  int checks = 0;
  int errors = 0;

  // Bench model state.
  logic m_active = 1'b0;
  int   m_done = 0;
  int   m_cnt = 0;

  floor_digit_blinker #(.CLK_HZ(HZ), .BLINKS(NBL), .FLOOR_W(3), .MAX_FLOOR(4)) u0 (
    .clk(clk), .rst(rst), .floor_idx(floor_idx), .arrive(arrive),
    .sec_tick(sec_tick), .seg_out(seg_out), .blink_on(blink_on)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Glyphs built from segment weights: a=64 b=32 c=16 d=8 e=4 f=2 g=1.
  function automatic logic [6:0] expect_glyph(input int f);
    int a = 64; int b = 32; int c = 16; int d = 8; int e = 4; int fs = 2; int g = 1;
    case (f)
      0: return 7'(a + b + c + d + e + fs);
      1: return 7'(b + c);
      2: return 7'(a + b + d + e + g);
      3: return 7'(a + b + c + d + g);
      4: return 7'(b + c + fs + g);
      default: return 7'd0;
    endcase
  endfunction

  task automatic compare(input string tag, input logic [6:0] es, input logic eb);
    checks++;
    if (seg_out !== es) begin
      errors++;
      $display("FAIL %s seg_out actual=%b expected=%b at %0t", tag, seg_out, es, $time);
    end
    checks++;
    if (blink_on !== eb) begin
      errors++;
      $display("FAIL %s blink_on actual=%b expected=%b at %0t", tag, blink_on, eb, $time);
    end
  endtask

  task automatic step(input string tag, input int fl, input logic arr, input logic tk);
    logic [6:0] es;
    logic       eb;
    floor_idx = 3'(fl);
    arrive    = arr;
    sec_tick  = tk;
    es = (m_active && !(m_cnt < HALF)) ? 7'd0 : expect_glyph(fl);
    eb = m_active;
    if (arr) begin
      m_active = 1'b1; m_done = 0;
    end else if (m_active && tk) begin
      if (m_done == NBL - 1) begin m_active = 1'b0; m_done = 0; end
      else m_done++;
    end
    if (arr || tk) m_cnt = 0;
    else if (m_cnt < HALF) m_cnt++;
    @(posedge clk);
    @(negedge clk);
    compare(tag, es, eb);
  endtask

  task automatic reset_step();
    rst = 1'b1; arrive = 1'b0; sec_tick = 1'b0;
    m_active = 1'b0; m_done = 0; m_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    compare("R3", 7'd0, 1'b0);
    rst = 1'b0;
  endtask

  // n ticks, each after period-1 quiet cycles.
  task automatic ticks(input string tag, input int fl, input int n, input int period);
    for (int t = 0; t < n; t++) begin
      for (int q = 0; q < period - 1; q++) step(tag, fl, 1'b0, 1'b0);
      step(tag, fl, 1'b0, 1'b1);
    end
  endtask

  task automatic quiet(input string tag, input int fl, input int n);
    for (int q = 0; q < n; q++) step(tag, fl, 1'b0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    reset_step();
    reset_step();
    // R1 R2 R9: sweep every index while idle.
    for (int f = 0; f < 8; f++) begin
      step((f > 4) ? "R2" : "R1", f, 1'b0, 1'b0);
      step("R9", f, 1'b0, 1'b0);
    end
    // R8: idle ticks change nothing.
    ticks("R8", 3, 3, 2);
    // R4 R5 R6: full sequence with one-second spacing.
    step("R4", 2, 1'b1, 1'b0);
    ticks("R5", 2, NBL - 1, HZ);
    quiet("R6", 2, HZ - 1);
    step("R6", 2, 1'b0, 1'b1);
    quiet("R6", 2, 12);
    // R7: restart mid-sequence.
    step("R4", 3, 1'b1, 1'b0);
    ticks("R7", 3, 2, HZ);
    step("R7", 3, 1'b1, 1'b0);
    ticks("R7", 3, NBL, HZ);
    quiet("R7", 3, 4);
    // R7: arrival and tick in the same cycle, during a sequence and from idle.
    step("R4", 1, 1'b1, 1'b0);
    ticks("R7", 1, 2, 5);
    step("R7", 1, 1'b1, 1'b1);
    ticks("R7", 1, NBL, 3);
    quiet("R7", 1, 3);
    step("R7", 0, 1'b1, 1'b1);
    ticks("R5", 0, NBL, 12);
    quiet("R5", 0, 3);
    // R10 R2: floor changes during a sequence.
    step("R4", 4, 1'b1, 1'b0);
    for (int f = 0; f < 8; f++) begin
      quiet("R10", f, 3);
      step("R10", f, 1'b0, (f % 2) == 1);
    end
    quiet("R10", 2, 20);
    // R3: reset in the middle of a sequence.
    step("R4", 2, 1'b1, 1'b0);
    quiet("R3", 2, 2);
    reset_step();
    quiet("R3", 2, 3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule